// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the SPI serial clock from the bus clock and gives the shift engine a strobe on each clock edge. The bus clock is divided in two stages. A prescaler stage picks one of four small divisors. A scaler stage picks one of sixteen divisors, which grow linearly at first and then in powers of two. A double-rate input halves the resulting period. That allows odd total divisions, down to a period of two bus cycles.

The shift engine raises the enable input to start the clock and lowers it to stop. While the enable is low, SCK rests at the selected polarity level. Each transition away from the rest level produces a one-cycle leading strobe. Each transition back to the rest level produces a one-cycle trailing strobe. The divider selects are read again at the start of every half-period, so a change takes effect at the next half-period boundary.

Top module: `spi_sck_gen`

## Requirements
- R1: Prescaler select codes 0, 1, 2 and 3 stand for divisors 2, 3, 5 and 7.
- R2: Scaler select codes 0 to 3 stand for divisors 2, 4, 6 and 8. A code c from 4 to 15 stands for 2 to the power c (16 up to 32768).
- R3: The SCK period in bus cycles is T = prescaler × scaler with double rate off, and T = prescaler × scaler / 2 with double rate on.
- R4: With double rate off, the two phases of SCK each last T/2 bus cycles.
- R5: In every mode, the phase at the non-rest level lasts floor(T/2) cycles and the rest-level phase lasts ceil(T/2) cycles. With double rate on and T odd, the active phase is therefore one cycle shorter.
- R6: After reset, and in the cycle after any clock edge that samples the enable low, sck_o equals cpol_i and both strobes are 0.
- R7: If the enable is sampled high at edge k after being low, the first SCK transition appears at edge k + ceil(T/2).
- R8: lead_o is 1 for exactly the one cycle that follows each SCK transition away from cpol_i, and 0 at all other times.
- R9: trail_o is 1 for exactly the one cycle that follows each SCK transition back to cpol_i, and 0 at all other times.
- R10: Lowering the enable while SCK is in its active phase returns SCK to the rest level on the next edge, with no trailing strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run request from the shift engine |
| cpol_i | input | 1 | SCK rest level |
| dbl_i | input | 1 | Double-rate select |
| presc_sel_i | input | 2 | Prescaler code |
| scale_sel_i | input | 4 | Scaler code |
| sck_o | output | 1 | Serial clock |
| lead_o | output | 1 | Strobe for an edge away from the rest level |
| trail_o | output | 1 | Strobe for an edge back to the rest level |

## Verification
The bench measures the length of every SCK phase. It goes after the smallest period of two cycles and after odd periods with double rate on. A design that rounded the wrong way in those cases would lengthen the active phase, or would merge the two phases and toggle every cycle.

The bench also times the first edge against the enable edge. An off-by-one reload shows up there as a first half-period one cycle short or long. Strobes are compared on every sample, which catches a swapped leading/trailing pair and a strobe fired when the enable drops. Every prescaler code and most scaler codes are swept. One large divisor checks that the upper counter bits carry correctly.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;
  localparam int PSEL_W = 2;
  localparam int SSEL_W = 4;
  localparam int PVAL_W = 3;
  localparam int SVAL_W = 16;
  localparam int PER_W  = PVAL_W + SVAL_W;
  localparam int CNT_W  = PER_W - 1;

  function automatic logic [PVAL_W-1:0] presc_div(input logic [PSEL_W-1:0] sel);
    case (sel)
      2'd0:    return PVAL_W'(2);
      2'd1:    return PVAL_W'(3);
      2'd2:    return PVAL_W'(5);
      default: return PVAL_W'(7);
    endcase
  endfunction

  function automatic logic [SVAL_W-1:0] scale_div(input logic [SSEL_W-1:0] sel);
    if (sel < SSEL_W'(4)) return SVAL_W'({sel, 1'b0} + 2);
    return SVAL_W'(1) << sel;
  endfunction
endpackage

// File: rtl/spi_sck_div_calc.sv
module spi_sck_div_calc
  import spi_sck_pkg::*;
(
  input  logic [PSEL_W-1:0] presc_sel_i,
  input  logic [SSEL_W-1:0] scale_sel_i,
  input  logic              dbl_i,
  output logic [CNT_W-1:0]  act_m1_o,
  output logic [CNT_W-1:0]  rest_m1_o
);
  logic [PER_W-1:0] full_per, per;
  logic [CNT_W-1:0] act_len, rest_len;

  assign full_per = PER_W'(presc_div(presc_sel_i)) * PER_W'(scale_div(scale_sel_i));
  assign per      = dbl_i ? (full_per >> 1) : full_per;
  // active phase takes the floor, rest phase the remainder
  assign act_len  = CNT_W'(per >> 1);
  assign rest_len = CNT_W'(per - PER_W'(act_len));
  assign act_m1_o  = act_len - CNT_W'(1);
  assign rest_m1_o = rest_len - CNT_W'(1);

  always_comb begin
    AST_ACT_LE_REST: assert (act_len <= rest_len && act_len != '0); // R5
  end
endmodule

// File: rtl/spi_sck_timer.sv
module spi_sck_timer
  import spi_sck_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] act_m1_i,
  input  logic [CNT_W-1:0] rest_m1_i,
  output logic             phase_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic             run_q, phase_q, lead_q, trail_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      if (!en_i) begin
        run_q   <= 1'b0;
        phase_q <= 1'b0;
        cnt_q   <= '0;
      end else if (!run_q) begin
        run_q <= 1'b1;
        cnt_q <= rest_m1_i;
      end else if (cnt_q == '0) begin
        phase_q <= ~phase_q;
        cnt_q   <= phase_q ? rest_m1_i : act_m1_i;
        lead_q  <= ~phase_q;
        trail_q <= phase_q;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign phase_o = phase_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;

  AST_IDLE_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !phase_q && !lead_q && !trail_q); // R6
  AST_FIRST_HALF_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> !phase_q); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_q && trail_q)); // R8
  AST_NO_STROBE_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !lead_q && !trail_q); // R10
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_sck_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic              dbl_i,
  input  logic [PSEL_W-1:0] presc_sel_i,
  input  logic [SSEL_W-1:0] scale_sel_i,
  output logic              sck_o,
  output logic              lead_o,
  output logic              trail_o
);
  logic [CNT_W-1:0] act_m1, rest_m1;
  logic             phase;

  spi_sck_div_calc i_calc (
    .presc_sel_i (presc_sel_i),
    .scale_sel_i (scale_sel_i),
    .dbl_i       (dbl_i),
    .act_m1_o    (act_m1),
    .rest_m1_o   (rest_m1)
  );

  spi_sck_timer i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .act_m1_i  (act_m1),
    .rest_m1_i (rest_m1),
    .phase_o   (phase),
    .lead_o    (lead_o),
    .trail_o   (trail_o)
  );

  assign sck_o = cpol_i ^ phase;

  AST_LEAD_MARKS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase) |-> lead_o); // R8
  AST_TRAIL_MARKS_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> !phase && $past(phase)); // R9
endmodule

// File: tb/test_spi_sck_gen.sv
module test_spi_sck_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, cpol = 1'b0, dbl = 1'b0;
  logic [1:0] psel = '0;
  logic [3:0] ssel = '0;
  logic       sck, lead, trail;
  int         vectors = 0, fails = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  spi_sck_gen i_spi_sck_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cpol_i(cpol), .dbl_i(dbl),
    .presc_sel_i(psel), .scale_sel_i(ssel),
    .sck_o(sck), .lead_o(lead), .trail_o(trail)
  );

  function automatic int ref_presc(input int c);
    int t[4] = '{2, 3, 5, 7};
    return t[c];
  endfunction

  function automatic int ref_scale(input int c);
    int t[16] = '{2, 4, 6, 8, 16, 32, 64, 128, 256, 512, 1024, 2048,
                  4096, 8192, 16384, 32768};
    return t[c];
  endfunction

  function automatic int ref_period(input int p, input int s, input bit d);
    int full = ref_presc(p) * ref_scale(s);
    return d ? full / 2 : full;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(sck == cpol, req, sck, cpol);
      chk(!lead && !trail, req, {lead, trail}, 0);
    end
  endtask

  // R1 R2 R3 R4 R5 R7 R8 R9: measure phases and strobes over nedges transitions
  task automatic run_cfg(input int p, input int s, input bit d, input bit pol, input int nedges);
    int  per, act_len, rest_len, run, edges;
    bit  prev, first;
    per = ref_period(p, s, d);
    act_len = per / 2;
    rest_len = per - act_len;
    @(negedge clk);
    psel = 2'(p); ssel = 4'(s); dbl = d; cpol = pol;
    en = 1'b1;
    prev = pol; run = 0; edges = 0; first = 1'b1;
    while (edges < nedges) begin
      @(negedge clk);
      if (sck != prev) begin
        if (first)
          chk(run == rest_len, "R7 first half", run, rest_len);
        else if (prev != pol)
          chk(run == act_len, "R5 active phase (R1 R2 R3 R4)", run, act_len);
        else
          chk(run == rest_len, "R5 rest phase (R1 R2 R3 R4)", run, rest_len);
        if (sck != pol) chk(lead && !trail, "R8 lead strobe", {lead, trail}, 2);
        else            chk(!lead && trail, "R9 trail strobe", {lead, trail}, 1);
        first = 1'b0; edges++; run = 1; prev = sck;
      end else begin
        chk(!lead && !trail, "R8 R9 quiet strobes", {lead, trail}, 0);
        run++;
      end
    end
    en = 1'b0;
    chk_idle(3, "R6 stop");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk(sck == 1'b0 && !lead && !trail, "R6 reset", {sck, lead, trail}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_idle(4, "R6 idle low");
    cpol = 1'b1;
    chk_idle(3, "R6 idle high");
    // R1: every prescaler code
    for (int p = 0; p < 4; p++) run_cfg(p, 0, 1'b0, 1'b0, 4);
    // R2: scaler codes 0..10
    for (int s = 0; s < 11; s++) run_cfg(0, s, 1'b1, 1'b0, 3);
    // R5 corner cases: smallest period and odd double-rate periods
    run_cfg(0, 0, 1'b1, 1'b0, 8);
    run_cfg(1, 0, 1'b1, 1'b0, 6);
    run_cfg(3, 0, 1'b1, 1'b1, 6);
    run_cfg(2, 0, 1'b1, 1'b1, 6);
    // R3: large divisor
    run_cfg(3, 12, 1'b0, 1'b0, 2);
    // R10: stop during the active phase
    @(negedge clk);
    psel = 2'd1; ssel = 4'd1; dbl = 1'b0; cpol = 1'b0; en = 1'b1;
    repeat (7) @(negedge clk);
    chk(sck == 1'b1, "R10 active before stop", sck, 1);
    en = 1'b0;
    chk_idle(4, "R10 stop mid-active");
    // constrained random
    for (int i = 0; i < 20; i++)
      run_cfg(int'($urandom_range(3, 0)), int'($urandom_range(7, 0)),
              bit'($urandom_range(1, 0)), bit'($urandom_range(1, 0)),
              int'($urandom_range(6, 2)));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule